// File: doc/BRIEF.md
# PWM Phase Timebase

This block is the shared timebase behind a bank of PWM channel generators. A programmable prescaler divides the system clock into beat ticks. On each beat a 16-bit phase accumulator advances by a power-of-two step. The step is chosen so that one pulse cycle always covers the full 2^16 phase range. The channel generators compare against the phase count and use the cycle-end strobe to frame their pulses.

Configuration arrives through a minimal register write port. One address holds the timebase configuration: divider, resolution and counter enable. The other address is a write-enable lock that can be dropped once and stays dropped until reset. To reconfigure, software writes the configuration as all zeros and then writes the new value. Clearing the enable returns the accumulator and the prescaler to zero, so every enable starts a fresh, aligned pulse cycle.

Top module: `pwm_tbase`

## Requirements
- R1: After reset, `phase_o` is 0, `beat_o` and `cycle_end_o` are 0, `regwen_o` is 1 and the counter is disabled, so no beat occurs.
- R2: While enabled with divider value D, `beat_o` pulses for one cycle every D+1 clocks. The first pulse comes D+1 clocks after the write that sets the enable.
- R3: On each beat `phase_o` advances by 2^(15-S) modulo 2^16, where S is the resolution field. `phase_o` changes in the same cycle that `beat_o` is high.
- R4: `cycle_end_o` is high for exactly the cycle in which a beat wrapped `phase_o` past zero. This happens once every 2^(S+1) beats after an enable.
- R5: While the enable bit is 0, `phase_o` is held at 0 and the prescaler count is held at 0, one cycle after the enable clears. After re-enabling, the first beat again takes D+1 clocks.
- R6: Writing a value with bit 0 equal to 0 to address 1 drops `regwen_o` to 0. Afterwards, writes to address 0 are ignored until reset.
- R7: Writing a value with bit 0 equal to 1 to address 1 has no effect. It neither locks nor unlocks.
- R8: A write to address 0 with `wr_en_i` high loads the configuration. The divider is `wr_data_i[11:0]`, the resolution S is `wr_data_i[15:12]` and the counter enable is `wr_data_i[16]`.
- R9: An active-low reset clears the lock and the configuration asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: configuration, 1: write-enable lock |
| wr_data_i | input | 17 | Write data |
| phase_o | output | 16 | Phase count shared by the channels |
| beat_o | output | 1 | One-cycle pulse on each phase advance |
| cycle_end_o | output | 1 | One-cycle pulse when the phase wraps |
| regwen_o | output | 1 | 1 while configuration writes are accepted |

## Verification
The bench sweeps divider and resolution pairs. These include a divider of zero, where a beat falls on every clock and a design that compared the count wrongly would skip or double beats. They also include the extreme resolutions 0 and 15, where a wrong shift width would give steps off by a factor of two or a step of zero. It counts beats up to the first wrap, so a strobe that fires one beat early or late, or never, is caught. It then disables and re-enables the counter: a prescaler count left stale would shorten the first beat. It drives the lock with both data values: an inverted lock sense, or a lock that reopens, would let an ignored configuration write stop the counter.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;
  parameter int unsigned DIV_W = 12;
  parameter int unsigned RES_W = 4;
  parameter int unsigned PH_W  = 16;

  typedef struct packed {
    logic             en;
    logic [RES_W-1:0] res;
    logic [DIV_W-1:0] div;
  } tbase_cfg_t;

  localparam int unsigned CFG_W = $bits(tbase_cfg_t);
  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_LOCK = 1'b1;
endpackage

// File: rtl/pwm_tbase_regs.sv
module pwm_tbase_regs
  import pwm_tbase_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output tbase_cfg_t       cfg_o,
  output logic             regwen_o
);
  tbase_cfg_t cfg_q;
  logic       regwen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      regwen_q <= 1'b1;
    end else if (wr_en_i && regwen_q) begin
      if (wr_addr_i == ADDR_CFG) begin
        cfg_q <= tbase_cfg_t'(wr_data_i);
      end else if (!wr_data_i[0]) begin
        regwen_q <= 1'b0;  // one-way: only reset reopens
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign regwen_o = regwen_q;
endmodule

// File: rtl/pwm_tbase_prescaler.sv
module pwm_tbase_prescaler
  import pwm_tbase_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the divider sane if the limit drops below the running count
  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_tbase_phase.sv
module pwm_tbase_phase
  import pwm_tbase_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [RES_W-1:0] res_i,
  output logic [PH_W-1:0]  step_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             beat_o,
  output logic             cycle_end_o
);
  localparam int unsigned TOP_SH = PH_W - 1;

  logic [PH_W-1:0] phase_q;
  logic            beat_q, end_q;
  logic [PH_W:0]   sum;

  always_comb begin
    step_o = '0;
    if (int'(res_i) >= TOP_SH) step_o[0] = 1'b1;
    else                       step_o[TOP_SH - int'(res_i)] = 1'b1;
  end

  assign sum = {1'b0, phase_q} + {1'b0, step_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      beat_q  <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      beat_q <= tick_i;
      end_q  <= tick_i && sum[PH_W];
      if (!en_i)       phase_q <= '0;
      else if (tick_i) phase_q <= sum[PH_W-1:0];
    end
  end

  assign phase_o     = phase_q;
  assign beat_o      = beat_q;
  assign cycle_end_o = end_q;
endmodule

// File: rtl/pwm_tbase.sv
module pwm_tbase
  import pwm_tbase_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             beat_o,
  output logic             cycle_end_o,
  output logic             regwen_o
);
  tbase_cfg_t      cfg;
  logic            tick;
  logic [PH_W-1:0] step;

  pwm_tbase_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cfg_o(cfg), .regwen_o
  );

  pwm_tbase_prescaler i_presc (
    .clk_i, .rst_ni, .en_i(cfg.en), .div_i(cfg.div), .tick_o(tick)
  );

  pwm_tbase_phase i_phase (
    .clk_i, .rst_ni, .en_i(cfg.en), .tick_i(tick), .res_i(cfg.res),
    .step_o(step), .phase_o, .beat_o, .cycle_end_o
  );
endmodule

// File: rtl/pwm_tbase_chk.sv
module pwm_tbase_chk
  import pwm_tbase_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input tbase_cfg_t      cfg_i,
  input logic [PH_W-1:0] step_i,
  input logic [PH_W-1:0] phase_i,
  input logic            beat_i,
  input logic            cycle_end_i,
  input logic            regwen_i
);
  a_r2_beat_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && cfg_i.div != '0) |=> !beat_i);

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> (phase_i == PH_W'($past(phase_i) + $past(step_i))));

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> (cycle_end_i == (phase_i < $past(phase_i))));

  a_r4_end_on_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_i |-> beat_i);

  a_r5_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> (phase_i == '0 && !beat_i));

  a_r6_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regwen_i |=> $stable(cfg_i));

  a_r6_stay_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regwen_i |=> !regwen_i);
endmodule

bind pwm_tbase pwm_tbase_chk i_chk (
  .clk_i, .rst_ni, .cfg_i(cfg), .step_i(step), .phase_i(phase_o),
  .beat_i(beat_o), .cycle_end_i(cycle_end_o), .regwen_i(regwen_o)
);

// File: tb/test_pwm_tbase.sv
module test_pwm_tbase;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 6;
  localparam int  MAXB = 40;
  // divider, resolution, expected step, expected beats per pulse cycle
  localparam int V_DIV[NV]  = '{0, 2, 5, 1, 0, 3};
  localparam int V_RES[NV]  = '{0, 3, 1, 15, 14, 4};
  localparam int V_STEP[NV] = '{32768, 4096, 16384, 1, 2, 2048};
  localparam int V_CYC[NV]  = '{2, 16, 4, 65536, 32768, 32};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [16:0] wr_data = '0;
  logic [15:0] phase;
  logic        beat, cyc_end, regwen;
  int          n_chk = 0;
  int          n_err = 0;

  pwm_tbase i_pwm_tbase (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .phase_o(phase), .beat_o(beat),
    .cycle_end_o(cyc_end), .regwen_o(regwen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] mk(input bit en, input int res, input int div);
    return {en, 4'(res), 12'(div)};
  endfunction

  task automatic wr(input logic a, input logic [16:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_beats(input int cycles, output int nb);
    nb = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (beat) nb++;
    end
  endtask

  task automatic first_latency(output int lat);
    lat = -1;
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      if (beat) begin lat = i; break; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int nb, lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase == 0 && !beat && !cyc_end, "R1 outputs in reset", phase, 0);
    chk(regwen == 1'b1, "R1 regwen in reset", regwen, 1);
    rst_n = 1'b1;
    count_beats(20, nb);
    chk(nb == 0, "R1 no beats after reset", nb, 0);

    // R2 R3 R4 R8 table walk
    for (int v = 0; v < NV; v++) begin
      int c, last, nbeat, flat, per_err, step_err, end_beats, prev_ph, exp_end;
      wr(1'b0, '0);
      wr(1'b0, mk(1'b1, V_RES[v], V_DIV[v]));
      c = 0; last = 0; nbeat = 0; flat = -1; per_err = 0; step_err = 0;
      end_beats = -1; prev_ph = 0;
      while (c < (V_DIV[v] + 1) * MAXB + 4) begin
        @(negedge clk);
        c++;
        if (beat) begin
          nbeat++;
          if (nbeat == 1) flat = c;
          else if (c - last != V_DIV[v] + 1) per_err++;
          if (int'(phase) != ((prev_ph + V_STEP[v]) % 65536)) step_err++;
          prev_ph = int'(phase);
          last = c;
          if (cyc_end && end_beats < 0) end_beats = nbeat;
        end
      end
      exp_end = (V_CYC[v] <= MAXB) ? V_CYC[v] : -1;
      chk(flat == V_DIV[v] + 1, "R2 first beat latency", flat, V_DIV[v] + 1);
      chk(per_err == 0, "R2 beat period", per_err, 0);
      chk(step_err == 0, "R3 R8 phase step", step_err, 0);
      chk(end_beats == exp_end, "R4 beats to cycle end", end_beats, exp_end);
    end

    // R5 disable clears phase and prescaler
    wr(1'b0, '0);
    wr(1'b0, mk(1'b1, 2, 4));
    repeat (13) @(negedge clk);
    wr(1'b0, mk(1'b0, 2, 4));
    @(negedge clk);
    chk(phase == 0, "R5 phase cleared", phase, 0);
    count_beats(20, nb);
    chk(nb == 0 && phase == 0, "R5 idle while disabled", nb, 0);
    wr(1'b0, mk(1'b1, 2, 4));
    first_latency(lat);
    chk(lat == 5, "R5 prescaler restarted", lat, 5);
    chk(phase == 16'h2000, "R5 phase restarted", phase, 16'h2000);

    // R6 R7 lock
    wr(1'b0, '0);
    wr(1'b0, mk(1'b1, 4, 3));
    wr(1'b1, 17'h1);
    chk(regwen == 1'b1, "R7 write of 1 keeps unlocked", regwen, 1);
    wr(1'b1, 17'h0);
    chk(regwen == 1'b0, "R6 lock drops regwen", regwen, 0);
    wr(1'b0, '0);
    count_beats(20, nb);
    chk(nb == 5, "R6 config write ignored when locked", nb, 5);
    wr(1'b1, 17'h1);
    chk(regwen == 1'b0, "R7 write of 1 does not unlock", regwen, 0);

    // R9 reset reopens
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(regwen == 1'b1 && phase == 0, "R9 async reset clears", regwen, 1);
    @(negedge clk);
    rst_n = 1'b1;
    count_beats(20, nb);
    chk(nb == 0, "R9 config cleared by reset", nb, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule